// File: doc/BRIEF.md
# Multi-channel endpoint DMA engine

This block moves data between USB endpoint FIFOs and system memory on eight independent channels. A host processor sets up a channel by writing its start address and byte count, then writes the channel's control word with the enable bit set. From then on the channel issues one memory beat at a time. It does so only while the endpoint named in its control word asserts its request line and the memory port grants. Each beat advances the channel's live address and reduces its remaining count. Software finds the number of bytes done by subtracting the start address it programmed from the final address it reads back.

Only one beat can go to memory in a cycle. When several channels are ready, the lowest-numbered one gets the memory port. The control word sets three things for the memory side: the direction (memory write for receive, memory read for transmit), the burst type, and the mode. In mode 1 a channel runs until its count is exhausted. In mode 0 it stops after one maximum-size packet. When a channel finishes or faults, it sets its bit in a shared 8-bit interrupt status register. Reading that register clears the bits it returned. One interrupt output is the OR of the status bits whose channels have interrupt enable set. A memory error ends the channel, sets its bus-error flag and posts its status bit.

Top module: `usb_ep_dma`

## Requirements
- R1: After reset, every channel is idle, every register reads 0, `irq` is 0 and `mem_req` is 0.
- R2: Registers are decoded on a 10-bit byte offset. The interrupt status register is at 0x200. Channel n uses 0x200+16n: control at +0x4, address at +0x8 and count at +0xC. Address and count read back as written. The control word reads back as follows: bit 0 enable, bit 1 direction (1 = transmit), bit 2 mode 1, bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus error, bits 10:9 burst type. All other bits read 0.
- R3: An enabled channel with a nonzero count requests memory only while `ep_req[endpoint]` is 1. Each granted beat without error moves min(4, count) bytes, raises the address by that amount and lowers the count by it.
- R4: In mode 1, the cycle after the beat that brings the count to 0, the channel clears its enable bit and sets its interrupt status bit.
- R5: In mode 0, the channel stops after 64 bytes or when the count reaches 0, whichever comes first. The unmoved count stays readable.
- R6: While a channel holds the memory port, `mem_write` is the inverse of its direction bit and `mem_burst` carries its burst field (0 unspecified, 1 INCR4, 2 INCR8, 3 INCR16).
- R7: Among ready channels, the lowest-numbered one is presented on the memory port, and `mem_chan` gives its number.
- R8: A granted beat with `mem_err` high leaves the address and count unchanged. It sets control bit 8, clears enable and sets the channel's status bit.
- R9: A read of 0x200 returns the status and clears the bits it returned. A bit set in the same cycle as the read stays set.
- R10: `irq` is 1 exactly when some status bit is set whose channel has interrupt enable set.
- R11: Writing 0 to a channel's control, address and count registers stops it at once. It makes no further requests and posts no status bit.
- R12: The count register holds values up to 0x10000. A full 0x10000-byte transfer advances the address by 0x10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on 0x200) |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| ep_req | input | 16 | Per-endpoint FIFO ready lines |
| mem_req | output | 1 | Memory beat request |
| mem_gnt | input | 1 | Memory beat accepted this cycle |
| mem_err | input | 1 | Error on the accepted beat |
| mem_addr | output | 32 | Beat address |
| mem_write | output | 1 | 1 = write memory (receive) |
| mem_burst | output | 2 | Burst type of the owning channel |
| mem_bytes | output | 3 | Bytes in this beat |
| mem_chan | output | 3 | Channel owning the beat |

## Verification
Several transfer shapes are used:
- A mode 1 receive whose count is not a multiple of four, which exposes an error in the tail-beat size.
- A mode 0 transmit longer than one packet, which separates the packet-limit stop from the count-exhausted stop.
- Two channels on one endpoint, which shows whether the lowest-numbered channel wins.
- A 64 KiB transfer, which exercises the widest count value.

The grant is driven always-on, alternating and pseudo-random, so the beat accounting is tried against stalls. A single error beat, an abort under a stalled grant, and a status read in the same cycle that a completion lands each test one corner of the status and control behaviour.

// File: rtl/usb_ep_dma.sv
module usb_ep_dma #(
  parameter int NCH    = 8,
  parameter int AW     = 32,
  parameter int MAXPKT = 64,
  parameter int BEAT   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [9:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   irq,
  input  logic [15:0]            ep_req,
  output logic                   mem_req,
  input  logic                   mem_gnt,
  input  logic                   mem_err,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_write,
  output logic [1:0]             mem_burst,
  output logic [$clog2(BEAT):0]  mem_bytes,
  output logic [$clog2(NCH)-1:0] mem_chan
);
  localparam int CW  = 17;
  localparam int BW  = $clog2(BEAT) + 1;
  localparam int PW  = $clog2(MAXPKT) + 1;
  localparam int CHW = $clog2(NCH);
  localparam logic [CW-1:0] BEAT_C = CW'(BEAT);
  localparam logic [PW-1:0] PKT_C  = PW'(MAXPKT);

  logic [NCH-1:0] en, dir, mode, ie, berr, st;
  logic [NCH-1:0] rdy, fin, hit, wsel, set_v;
  logic [3:0]     ep    [NCH];
  logic [1:0]     burst [NCH];
  logic [AW-1:0]  addr  [NCH];
  logic [CW-1:0]  cnt   [NCH];
  logic [PW-1:0]  pkt   [NCH];
  logic [CHW-1:0] sel;
  logic [BW-1:0]  bytes;

  wire       win   = reg_addr[9] && (reg_addr[8:7] == 2'b00);
  wire [2:0] rch   = reg_addr[6:4];
  wire [1:0] roff  = reg_addr[3:2];
  wire       rd_st = reg_rd && win && (rch == 3'd0) && (roff == 2'd0);
  wire [CHW-1:0] ridx = rch[CHW-1:0];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      rdy[i] = en[i] && (cnt[i] != '0) && ep_req[ep[i]] && (mode[i] || (pkt[i] < PKT_C));
      fin[i] = en[i] && ((cnt[i] == '0) || (!mode[i] && (pkt[i] >= PKT_C)));
    end
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (rdy[i]) sel = CHW'(i);
  end

  assign bytes     = (cnt[sel] < BEAT_C) ? cnt[sel][BW-1:0] : BW'(BEAT);
  assign mem_req   = |rdy;
  assign mem_chan  = sel;
  assign mem_addr  = addr[sel];
  assign mem_write = !dir[sel];
  assign mem_burst = burst[sel];
  assign mem_bytes = bytes;
  assign irq       = |(st & ie);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wsel[g]  = reg_wr && win && (roff != 2'd0) && (rch == 3'(g));
    assign hit[g]   = mem_req && mem_gnt && (sel == CHW'(g));
    assign set_v[g] = !wsel[g] && (fin[g] || (hit[g] && mem_err));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[g] <= 1'b0; dir[g] <= 1'b0; mode[g] <= 1'b0; ie[g] <= 1'b0; berr[g] <= 1'b0;
        ep[g] <= '0; burst[g] <= '0; addr[g] <= '0; cnt[g] <= '0; pkt[g] <= '0;
      end else if (wsel[g]) begin
        case (roff)
          2'd1: begin
            en[g]    <= reg_wdata[0];
            dir[g]   <= reg_wdata[1];
            mode[g]  <= reg_wdata[2];
            ie[g]    <= reg_wdata[3];
            ep[g]    <= reg_wdata[7:4];
            burst[g] <= reg_wdata[10:9];
            berr[g]  <= 1'b0;
            pkt[g]   <= '0;
          end
          2'd2:    addr[g] <= reg_wdata[AW-1:0];
          default: cnt[g]  <= reg_wdata[CW-1:0];
        endcase
      end else if (fin[g]) begin
        en[g] <= 1'b0;
      end else if (hit[g]) begin
        if (mem_err) begin
          berr[g] <= 1'b1;
          en[g]   <= 1'b0;
        end else begin
          addr[g] <= addr[g] + AW'(bytes);
          cnt[g]  <= cnt[g] - CW'(bytes);
          pkt[g]  <= pkt[g] + PW'(bytes);
        end
      end
    end

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !mem_err && !wsel[g]) |=> (addr[g] == $past(addr[g]) + AW'($past(mem_bytes))));
    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && mem_err && !wsel[g]) |=> (!en[g] && berr[g] && st[g] && $stable(addr[g])));
    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel[g] && (roff == 2'd1) && !reg_wdata[0]) |=> !rdy[g]);
    // R5
    pkt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && !mode[g]) |-> (pkt[g] <= PKT_C));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= '0;
    else if (rd_st) st <= set_v;
    else            st <= st | set_v;
  end

  always_comb begin
    reg_rdata = '0;
    if (win && (int'(rch) < NCH)) begin
      case (roff)
        2'd0:    if (rch == 3'd0) reg_rdata = 32'(st);
        2'd1:    reg_rdata = {21'd0, burst[ridx], berr[ridx], ep[ridx], ie[ridx],
                              mode[ridx], dir[ridx], en[ridx]};
        2'd2:    reg_rdata = 32'(addr[ridx]);
        default: reg_rdata = 32'(cnt[ridx]);
      endcase
    end
  end

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((rdy & ((NCH'(1) << mem_chan) - NCH'(1))) == '0));
  // R3
  ep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (ep_req[ep[mem_chan]] && (cnt[mem_chan] != '0)));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |=> ((st & ~$past(set_v)) == '0));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == '0) |-> !irq);
endmodule

// File: tb/test_usb_ep_dma.sv
module test_usb_ep_dma;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic [15:0] ep_req = '0;
  logic mem_req, mem_gnt = 0, mem_err = 0, mem_write;
  logic [31:0] mem_addr;
  logic [1:0] mem_burst;
  logic [2:0] mem_bytes, mem_chan;

  usb_ep_dma i_usb_ep_dma (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, gpat = 0, err_shots = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int m_en[8], m_dir[8], m_mode[8], m_ie[8], m_berr[8], m_ep[8], m_burst[8], m_cnt[8], m_pkt[8];
  logic [31:0] m_addr[8];
  logic [7:0] m_st;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_sel();
    for (int i = 0; i < 8; i++)
      if (m_en[i] != 0 && m_cnt[i] > 0 && ep_req[m_ep[i]] && (m_mode[i] != 0 || m_pkt[i] < 64))
        return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_en[i] = 0; m_dir[i] = 0; m_mode[i] = 0; m_ie[i] = 0; m_berr[i] = 0;
        m_ep[i] = 0; m_burst[i] = 0; m_cnt[i] = 0; m_pkt[i] = 0; m_addr[i] = 0;
      end
      m_st = 0;
    end else begin
      int s, b, ch, off;
      logic [7:0] setb;
      setb = 0;
      s = m_sel();
      b = (s >= 0) ? ((m_cnt[s] < 4) ? m_cnt[s] : 4) : 0;
      ch = reg_addr[6:4];
      off = reg_addr[3:2];
      for (int i = 0; i < 8; i++) begin
        if (reg_wr && reg_addr[9:7] == 3'b100 && ch == i && off != 0) begin
          if (off == 1) begin
            m_en[i] = reg_wdata[0]; m_dir[i] = reg_wdata[1]; m_mode[i] = reg_wdata[2];
            m_ie[i] = reg_wdata[3]; m_ep[i] = reg_wdata[7:4]; m_burst[i] = reg_wdata[10:9];
            m_berr[i] = 0; m_pkt[i] = 0;
          end else if (off == 2) m_addr[i] = reg_wdata;
          else m_cnt[i] = reg_wdata[16:0];
        end else if (m_en[i] != 0 && (m_cnt[i] == 0 || (m_mode[i] == 0 && m_pkt[i] >= 64))) begin
          m_en[i] = 0; setb[i] = 1;
        end else if (s == i && mem_gnt) begin
          if (mem_err) begin m_berr[i] = 1; m_en[i] = 0; setb[i] = 1; end
          else begin m_addr[i] += b; m_cnt[i] -= b; m_pkt[i] += b; end
        end
      end
      if (reg_rd && reg_addr == 10'h200) m_st = setb;
      else m_st = m_st | setb;
    end
  end

  // grant / error driver
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (err_shots > 0) begin mem_gnt = 1; mem_err = 1; err_shots--; end
    else begin
      mem_err = 0;
      case (gpat)
        1: mem_gnt = 1;
        2: mem_gnt = cyc[0];
        3: mem_gnt = lfsr[0];
        default: mem_gnt = 0;
      endcase
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      int s;
      logic [7:0] ien;
      s = m_sel();
      ien = 0;
      for (int i = 0; i < 8; i++) ien[i] = (m_ie[i] != 0);
      chk("R3 mem_req", 32'(mem_req), 32'(s >= 0));
      chk("R10 irq", 32'(irq), 32'(|(m_st & ien)));
      if (s >= 0 && mem_req) begin
        chk("R7 mem_chan", 32'(mem_chan), 32'(s));
        chk("R3 mem_addr", mem_addr, m_addr[s]);
        chk("R3 mem_bytes", 32'(mem_bytes), 32'((m_cnt[s] < 4) ? m_cnt[s] : 4));
        chk("R6 mem_write", 32'(mem_write), 32'(m_dir[s] == 0));
        chk("R6 mem_burst", 32'(mem_burst), 32'(m_burst[s]));
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_rd = 1; reg_addr = a;
    #4 d = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic wait_done(input int ch);
    int n;
    n = 0;
    while (m_en[ch] != 0 && n < 100000) begin @(negedge clk); n++; end
    @(negedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<190000", wd);
      finish_run();
    end
  end

  logic [31:0] v;
  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    rd(10'h200, v); chk("R1 status", v, 0);
    rd(10'h234, v); chk("R1 ctrl", v, 0);
    rd(10'h238, v); chk("R1 addr", v, 0);

    // R2 register decode and readback
    wr(10'h238, 32'h1000_0000);
    wr(10'h23C, 32'h40);
    wr(10'h234, 32'h678);
    rd(10'h238, v); chk("R2 addr", v, 32'h1000_0000);
    rd(10'h23C, v); chk("R2 count", v, 32'h40);
    rd(10'h234, v); chk("R2 ctrl", v, 32'h678);
    wr(10'h234, 0); wr(10'h238, 0); wr(10'h23C, 0);

    // R3 / R4 / R10 mode 1 receive with a short tail
    gpat = 1;
    wr(10'h208, 32'h100);
    wr(10'h20C, 10);
    wr(10'h204, 32'h2D);
    idle(5);
    chk("R3 gated mem_req", 32'(mem_req), 0);
    rd(10'h20C, v); chk("R3 gated count", v, 10);
    ep_req[2] = 1;
    wait_done(0);
    rd(10'h208, v); chk("R3 final addr", v, 32'h10A);
    rd(10'h20C, v); chk("R4 final count", v, 0);
    rd(10'h204, v); chk("R4 enable cleared", v, 32'h2C);
    chk("R10 irq high", 32'(irq), 1);
    rd(10'h200, v); chk("R9 status read", v, 32'h01);
    idle(1);
    chk("R10 irq after clear", 32'(irq), 0);
    rd(10'h200, v); chk("R9 status cleared", v, 0);

    // R9 read in the same cycle as a completion
    wr(10'h20C, 4);
    wr(10'h204, 32'h2D);
    rd(10'h200, v); chk("R9 concurrent read", v, 0);
    rd(10'h200, v); chk("R9 concurrent bit kept", v, 32'h01);

    // R5 / R6 mode 0 transmit, INCR8
    gpat = 2;
    ep_req[3] = 1;
    wr(10'h218, 32'h2000);
    wr(10'h21C, 200);
    wr(10'h214, 32'h433);
    idle(2);
    chk("R6 mem_write tx", 32'(mem_write), 0);
    chk("R6 mem_burst", 32'(mem_burst), 2);
    wait_done(1);
    rd(10'h218, v); chk("R5 packet addr", v, 32'h2040);
    rd(10'h21C, v); chk("R5 remaining count", v, 136);
    chk("R10 irq masked", 32'(irq), 0);
    rd(10'h200, v); chk("R5 status", v, 32'h02);

    // R7 two channels, one endpoint
    gpat = 1;
    wr(10'h258, 32'h5000); wr(10'h25C, 16); wr(10'h254, 32'h45);
    wr(10'h228, 32'h3000); wr(10'h22C, 8);  wr(10'h224, 32'h45);
    @(negedge clk); #1 ep_req[4] = 1;
    #4 chk("R7 lowest first", 32'(mem_chan), 2);
    wait_done(5);
    rd(10'h258, v); chk("R7 ch5 addr", v, 32'h5010);
    rd(10'h228, v); chk("R7 ch2 addr", v, 32'h3008);
    rd(10'h200, v); chk("R7 status", v, 32'h24);

    // R8 bus error
    gpat = 0;
    ep_req[5] = 1;
    wr(10'h248, 32'h4000); wr(10'h24C, 32); wr(10'h244, 32'h5D);
    idle(2);
    err_shots = 1;
    idle(3);
    rd(10'h244, v); chk("R8 ctrl", v, 32'h15C);
    rd(10'h248, v); chk("R8 addr", v, 32'h4000);
    rd(10'h24C, v); chk("R8 count", v, 32);
    chk("R8 irq", 32'(irq), 1);
    rd(10'h200, v); chk("R8 status", v, 32'h10);

    // R11 abort while stalled
    ep_req[6] = 1;
    wr(10'h268, 32'h6000); wr(10'h26C, 100); wr(10'h264, 32'h6D);
    idle(3);
    chk("R11 pending req", 32'(mem_req), 1);
    wr(10'h264, 0); wr(10'h268, 0); wr(10'h26C, 0);
    chk("R11 req dropped", 32'(mem_req), 0);
    gpat = 1;
    idle(5);
    rd(10'h264, v); chk("R11 ctrl", v, 0);
    rd(10'h268, v); chk("R11 addr", v, 0);
    rd(10'h26C, v); chk("R11 count", v, 0);
    rd(10'h200, v); chk("R11 no status", v, 0);

    // R12 full 64 KiB transfer
    gpat = 3;
    ep_req[7] = 1;
    wr(10'h278, 32'h8000_0000);
    wr(10'h27C, 32'h10000);
    rd(10'h27C, v); chk("R12 count readback", v, 32'h10000);
    wr(10'h274, 32'h7D);
    wait_done(7);
    rd(10'h278, v); chk("R12 final addr", v, 32'h8001_0000);
    rd(10'h27C, v); chk("R12 final count", v, 0);
    rd(10'h200, v); chk("R12 status", v, 32'h80);

    finish_run();
  end
endmodule